// File: doc/BRIEF.md
# Scan Register with Shift Priority

This block is a parameterised edge-triggered register, eight bits wide by default, with three ways to change its contents: take a parallel word, keep what it has, or move one place toward the top bit while a serial bit comes in at the bottom. Two control lines choose the mode. The shift line has priority over the hold/load line. A datapath can therefore switch between hold and load with one wire, and a test controller can switch the whole register into a scan chain with another wire. No decoding of the two is needed outside the block.

During a shift the top bit leaves the register. It is visible on the top output bit before the edge that drops it, so the top output bit of one register can feed the serial input of the next to form a scan path. A high level on the clear input forces every bit to zero at once, without a clock edge, and clock edges do nothing while clear stays high.

Top module: `scan_register`

## Requirements
- R1: While `mclr` is 1 the output `q` is all zeros, and it goes to zero as soon as `mclr` rises, before any clock edge.
- R2: When `shift_en` is 1 at a rising edge of `clk`, the register shifts whatever the value of `load_en`: each bit i gets the old bit i-1, and the old top bit is lost.
- R3: When `shift_en` is 0 and `load_en` is 1 at a rising edge, `q` takes the value of `par_d`.
- R4: When `shift_en` is 0 and `load_en` is 0 at a rising edge, `q` keeps its value.
- R5: In a shift, bit 0 takes the value of `scan_in`.
- R6: After a parallel load, eight shifts in a row present the loaded word on `q[7]`, most significant bit first, each bit before the edge that drops it. The eight `scan_in` bits fed in during those shifts, in order, end up in `q` with the first bit in bit 7.
- R7: Rising edges of `clk` while `mclr` is 1 do not change `q`. The first rising edge after `mclr` falls acts normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| mclr | input | 1 | Asynchronous clear, active high |
| shift_en | input | 1 | 1 selects serial shift and overrides load_en |
| load_en | input | 1 | With shift_en at 0: 1 loads par_d, 0 holds |
| par_d | input | 8 | Parallel data word |
| scan_in | input | 1 | Serial bit that enters bit 0 during a shift |
| q | output | 8 | Register contents; q[7] is the scan output |

## Verification
The bench targets the priority of shift over load. If a design let `load_en` win, the shift rows that also have `load_en` at 1 would show `par_d` on `q`. It raises the clear between clock edges and checks `q` before the next edge; a design with a synchronous clear would still show the old data there. It also clocks the register while clear is held high. Finally, a full scan-out and scan-in checks the shift direction and the bit order: a design that shifted the wrong way or dropped the wrong end would give a reversed or corrupted word on `q[7]` and in the final contents.

// File: rtl/scan_register_pkg.sv
// Package: shared mode type for the scan register.
// Assumes: exactly three operating modes; encoding carries no meaning outside the block.
package scan_register_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD  = 2'd0,
        MODE_LOAD  = 2'd1,
        MODE_SHIFT = 2'd2
    } sr_mode_e;

endpackage

// File: rtl/scan_register_mode_dec.sv
// Module: scan_register_mode_dec
// Does: turns the two control lines into one mode, shift taking priority.
// Assumes: controls are stable around the clock edge (synchronous to clk).
module scan_register_mode_dec
    import scan_register_pkg::*;
(
    input  logic     shift_en,
    input  logic     load_en,
    output sr_mode_e mode
);

    // Priority decode: shift first, then load versus hold.
    always_comb begin
        if (shift_en) begin
            mode = MODE_SHIFT;
        end else if (load_en) begin
            mode = MODE_LOAD;
        end else begin
            mode = MODE_HOLD;
        end
    end

endmodule

// File: rtl/scan_register_cell.sv
// Module: scan_register_cell
// Does: one stored bit that can hold, take its parallel bit, or take its serial neighbour.
// Assumes: mclr is asynchronous and active high; everything else is sampled on clk rising.
module scan_register_cell
    import scan_register_pkg::*;
(
    input  logic     clk,
    input  logic     mclr,
    input  sr_mode_e mode,
    input  logic     par_bit,
    input  logic     ser_bit,
    output logic     q_bit
);

    logic next_bit;

    // Choose the value the bit takes at the next edge.
    always_comb begin
        case (mode)
            MODE_LOAD:  next_bit = par_bit;
            MODE_SHIFT: next_bit = ser_bit;
            default:    next_bit = q_bit;
        endcase
    end

    // Storage with immediate clear.
    always_ff @(posedge clk or posedge mclr) begin
        if (mclr) begin
            q_bit <= 1'b0;
        end else begin
            q_bit <= next_bit;
        end
    end

endmodule

// File: rtl/scan_register.sv
// Module: scan_register
// Does: WIDTH-bit register with parallel load, hold and upward serial shift; shift overrides load.
// Assumes: WIDTH >= 2; scan_in enters bit 0, q[WIDTH-1] is the scan output.
module scan_register
    import scan_register_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             mclr,
    input  logic             shift_en,
    input  logic             load_en,
    input  logic [WIDTH-1:0] par_d,
    input  logic             scan_in,
    output logic [WIDTH-1:0] q
);

    localparam int MSB = WIDTH - 1;

    sr_mode_e         mode;
    logic [WIDTH-1:0] ser_chain;

    // One shared mode decode for all bits.
    scan_register_mode_dec u_dec (
        .shift_en (shift_en),
        .load_en  (load_en),
        .mode     (mode)
    );

    // Serial feed: bit 0 from scan_in, every other bit from the bit below.
    assign ser_chain[0] = scan_in;
    for (genvar gi = 1; gi <= MSB; gi++) begin : g_chain
        assign ser_chain[gi] = q[gi-1];
    end

    // One storage cell per bit.
    for (genvar gb = 0; gb <= MSB; gb++) begin : g_bit
        scan_register_cell u_cell (
            .clk     (clk),
            .mclr    (mclr),
            .mode    (mode),
            .par_bit (par_d[gb]),
            .ser_bit (ser_chain[gb]),
            .q_bit   (q[gb])
        );
    end

endmodule

// File: rtl/scan_register_chk.sv
// Module: scan_register_chk
// Does: temporal checks on the scan register ports, attached by bind.
// Assumes: same WIDTH as the checked instance.
module scan_register_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             mclr,
    input logic             shift_en,
    input logic             load_en,
    input logic [WIDTH-1:0] par_d,
    input logic             scan_in,
    input logic [WIDTH-1:0] q
);

    // R1 / R7: clear held at an edge means zero contents.
    assert_clear_zero_R1: assert property (@(posedge clk) mclr |-> (q == '0));

    // R7: a clocked edge with clear high leaves zero behind it.
    assert_clear_edge_R7: assert property (@(posedge clk) (mclr && $past(mclr)) |-> (q == '0));

    // R2: shift wins over load.
    assert_shift_prio_R2: assert property (@(posedge clk) disable iff (mclr)
        shift_en |=> (q[WIDTH-1:1] == $past(q[WIDTH-2:0])));

    // R5: serial bit enters at bit 0.
    assert_scan_entry_R5: assert property (@(posedge clk) disable iff (mclr)
        shift_en |=> (q[0] == $past(scan_in)));

    // R3: parallel load.
    assert_load_R3: assert property (@(posedge clk) disable iff (mclr)
        (!shift_en && load_en) |=> (q == $past(par_d)));

    // R4: hold keeps contents.
    assert_hold_R4: assert property (@(posedge clk) disable iff (mclr)
        (!shift_en && !load_en) |=> $stable(q));

endmodule

bind scan_register scan_register_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .mclr     (mclr),
    .shift_en (shift_en),
    .load_en  (load_en),
    .par_d    (par_d),
    .scan_in  (scan_in),
    .q        (q)
);

// File: tb/scan_register_bench.sv
module scan_register_bench;

    typedef struct packed {
        logic       sh;
        logic       ld;
        logic [7:0] d;
        logic       si;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b1, 8'hA5, 1'b0},  // R3 load
        '{1'b0, 1'b0, 8'h3C, 1'b1},  // R4 hold
        '{1'b1, 1'b0, 8'hFF, 1'b1},  // R2 R5 shift, in 1
        '{1'b1, 1'b1, 8'h00, 1'b0},  // R2 shift beats load
        '{1'b1, 1'b1, 8'h77, 1'b1},  // R2 shift beats load
        '{1'b0, 1'b1, 8'h81, 1'b0},  // R3 load
        '{1'b0, 1'b0, 8'h00, 1'b0},  // R4 hold
        '{1'b1, 1'b0, 8'h12, 1'b0},  // R2 shift
        '{1'b0, 1'b1, 8'hFF, 1'b1},  // R3 load all ones
        '{1'b1, 1'b1, 8'h00, 1'b0},  // R2 top bit dropped
        '{1'b0, 1'b0, 8'h55, 1'b1},  // R4 hold
        '{1'b0, 1'b1, 8'h00, 1'b1}   // R3 load zero
    };

    logic       clk = 1'b0;
    logic       mclr;
    logic       shift_en;
    logic       load_en;
    logic [7:0] par_d;
    logic       scan_in;
    logic [7:0] q;

    int checks   = 0;
    int failures = 0;
    logic [7:0] model;
    bit         done = 0;

    always #5 clk = ~clk;

    scan_register u_scan_register (
        .clk      (clk),
        .mclr     (mclr),
        .shift_en (shift_en),
        .load_en  (load_en),
        .par_d    (par_d),
        .scan_in  (scan_in),
        .q        (q)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_next(input logic [7:0] cur, input logic sh,
                                            input logic ld, input logic [7:0] d, input logic si);
        if (sh) return {cur[6:0], si};
        if (ld) return d;
        return cur;
    endfunction

    initial begin
        #2000000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        mclr = 1'b1; shift_en = 1'b0; load_en = 1'b0; par_d = 8'h00; scan_in = 1'b0;
        #1;
        check("R1 reset state", q, 8'h00);
        repeat (2) @(posedge clk);
        @(negedge clk);
        mclr = 1'b0;
        model = 8'h00;

        // Table walk against the reference model.
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            shift_en = VECS[i].sh; load_en = VECS[i].ld;
            par_d = VECS[i].d; scan_in = VECS[i].si;
            @(posedge clk);
            #1;
            model = ref_next(model, VECS[i].sh, VECS[i].ld, VECS[i].d, VECS[i].si);
            check(VECS[i].sh ? "R2 R5 shift" : (VECS[i].ld ? "R3 load" : "R4 hold"), q, model);
        end

        // R1: clear between edges acts at once.
        @(negedge clk);
        shift_en = 1'b0; load_en = 1'b1; par_d = 8'hE7;
        @(posedge clk); #1;
        check("R3 load before clear", q, 8'hE7);
        @(negedge clk);
        #2 mclr = 1'b1;
        #1 check("R1 async clear mid-cycle", q, 8'h00);
        // R7: edges while clear high do nothing.
        par_d = 8'h5A;
        @(posedge clk); #1;
        check("R7 edge during clear", q, 8'h00);
        @(negedge clk);
        mclr = 1'b0; par_d = 8'h3C;
        @(posedge clk); #1;
        check("R7 first edge after clear", q, 8'h3C);

        // R6: load, then scan out the word and scan in a new one.
        @(negedge clk);
        load_en = 1'b1; par_d = 8'hB4;
        @(posedge clk); #1;
        check("R6 load scan word", q, 8'hB4);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            shift_en = 1'b1; load_en = k[0]; par_d = 8'hFF;
            scan_in = logic'((8'h5B >> (7 - k)) & 8'h01);
            check("R6 scan out bit", {7'b0, q[7]}, {7'b0, 1'(8'hB4 >> (7 - k))});
            @(posedge clk); #1;
        end
        check("R6 scan in word", q, 8'h5B);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule